// File: doc/BRIEF.md
# Critical-Word-First Line Fill Unit

This unit refills one cache line over a memory bus that is narrower than the line, so a refill arrives as several bus beats. It takes the address of a missing access, asks memory for the line starting at the word that missed, and hands that word to the processor as soon as the first beat arrives. Execution can then resume before the rest of the line is in.

The remaining beats arrive in wrap-around order. They run from the critical word up to the last word of the line, then from word 0 up to the word just before the critical one. The unit writes each beat into its slot in a line buffer and pulses a completion flag once the whole line is assembled. Tag lookup and victim choice belong to the surrounding cache; this unit only sequences beats, forwards the first one and builds the line.

Only one fill is in flight at a time. While a fill runs, the unit reports itself busy and refuses new requests.

Top module: `cwf_line_fill`

## Requirements
- R1: Out of reset and whenever no fill is active, `busy` is 0 and `req_ready` is 1. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1, and `busy` is 1 from the next cycle.
- R2: In the cycle after a request is taken, `mem_req_valid` rises. It stays high with `mem_req_addr` stable until an edge where `mem_req_ready` is 1. `mem_req_addr` is the request address with its low log2(BUS_BITS/8) byte-offset bits cleared.
- R3: `mem_beat_valid` has no effect while the unit is idle, or while the memory request is still waiting for `mem_req_ready`.
- R4: The critical index is `req_addr[BYTE_W +: IDX_W]`, where BYTE_W = log2(BUS_BITS/8) and IDX_W = log2(LINE_BITS/BUS_BITS). Beat k of a fill (counting from 0) goes into word slot (critical index + k) mod BEATS. Slot j occupies `line_data[j*BUS_BITS +: BUS_BITS]`.
- R5: `cpu_word_valid` is a one-cycle pulse in the cycle after the first beat of a fill is taken, with `cpu_word_data` equal to that beat. It pulses once per fill.
- R6: `line_done` is a one-cycle pulse in the cycle after the BEATS-th beat is taken. In that same cycle `busy` is 0 and `req_ready` is 1.
- R7: A `req_valid` seen while a fill is active is dropped. It starts no memory request, neither during the fill nor after it.
- R8: Cycles without `mem_beat_valid` during a fill are skipped. Only valid beats advance the slot sequence.
- R9: Reset clears `line_data`, `cpu_word_valid`, `line_done` and `mem_req_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Miss request strobe |
| req_addr | input | ADDR_BITS | Byte address of the missing access |
| req_ready | output | 1 | Unit can take a request |
| busy | output | 1 | A fill is in progress |
| mem_req_valid | output | 1 | Line request to memory pending |
| mem_req_addr | output | ADDR_BITS | Word-aligned address of the critical word |
| mem_req_ready | input | 1 | Memory takes the line request |
| mem_beat_valid | input | 1 | Memory beat present |
| mem_beat_data | input | BUS_BITS | Memory beat payload |
| cpu_word_valid | output | 1 | Critical word forwarded to the processor |
| cpu_word_data | output | BUS_BITS | Critical word payload |
| line_done | output | 1 | Line fully assembled |
| line_data | output | LINE_BITS | Assembled line, slot j at bits j*BUS_BITS upward |

## Verification
Each result has a fixed lag. `busy` and `mem_req_valid` react one cycle after the request edge. The forwarded word and `line_done` appear one cycle after the beat that causes them. `line_data` shows a slot one cycle after its beat is taken. The bench drives inputs on the falling edge and advances a behavioural model on the rising edge with the same inputs. It compares every output on the next falling edge, so each expected value is checked in exactly the cycle it is due. When `line_done` shows, the assembled line is also checked against the memory image the responder served. Stray beats, requests made while busy and idle gaps are mixed into the traffic.

// File: rtl/cwf_line_fill.sv
module cwf_line_fill #(
  parameter int LINE_BITS = 256,
  parameter int BUS_BITS  = 32,
  parameter int ADDR_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [ADDR_BITS-1:0] req_addr,
  output logic                 req_ready,
  output logic                 busy,
  output logic                 mem_req_valid,
  output logic [ADDR_BITS-1:0] mem_req_addr,
  input  logic                 mem_req_ready,
  input  logic                 mem_beat_valid,
  input  logic [BUS_BITS-1:0]  mem_beat_data,
  output logic                 cpu_word_valid,
  output logic [BUS_BITS-1:0]  cpu_word_data,
  output logic                 line_done,
  output logic [LINE_BITS-1:0] line_data
);

  localparam int BEATS  = LINE_BITS / BUS_BITS;
  localparam int IDX_W  = $clog2(BEATS);
  localparam int BYTE_W = $clog2(BUS_BITS / 8);
  localparam logic [ADDR_BITS-1:0] LOW_MASK = (ADDR_BITS'(1) << BYTE_W) - ADDR_BITS'(1);
  localparam logic [IDX_W-1:0] LAST_CNT = IDX_W'(BEATS - 1);

  typedef enum logic [1:0] {S_IDLE, S_ASK, S_FILL} state_t;

  state_t           state;
  logic [IDX_W-1:0] crit;
  logic [IDX_W-1:0] cnt;

  wire take_req  = req_valid && (state == S_IDLE);
  wire take_beat = mem_beat_valid && (state == S_FILL);
  wire last_beat = take_beat && (cnt == LAST_CNT);
  wire [IDX_W-1:0] wr_idx = crit + cnt;

  assign req_ready     = (state == S_IDLE);
  assign busy          = (state != S_IDLE);
  assign mem_req_valid = (state == S_ASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      crit         <= '0;
      cnt          <= '0;
      mem_req_addr <= '0;
    end else begin
      case (state)
        S_IDLE: if (take_req) begin
          state        <= S_ASK;
          crit         <= req_addr[BYTE_W +: IDX_W];
          mem_req_addr <= req_addr & ~LOW_MASK;
        end
        S_ASK: if (mem_req_ready) begin
          state <= S_FILL;
          cnt   <= '0;
        end
        S_FILL: if (take_beat) begin
          cnt <= cnt + IDX_W'(1);
          if (last_beat) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_word_valid <= 1'b0;
      cpu_word_data  <= '0;
      line_done      <= 1'b0;
    end else begin
      cpu_word_valid <= take_beat && (cnt == '0);
      line_done      <= last_beat;
      if (take_beat && (cnt == '0)) cpu_word_data <= mem_beat_data;
    end
  end

  for (genvar j = 0; j < BEATS; j++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        line_data[j*BUS_BITS +: BUS_BITS] <= '0;
      else if (take_beat && (wr_idx == IDX_W'(j)))
        line_data[j*BUS_BITS +: BUS_BITS] <= mem_beat_data;
    end
  end

  a_r1_start_from_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  a_r2_hold_mem_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r5_forward_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_word_valid |-> $past(mem_beat_valid) && cpu_word_data == $past(mem_beat_data));

  a_r6_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> $past(mem_beat_valid) && !busy);

  a_r8_no_beat_no_finish: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_beat_valid |=> busy);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_word_valid |=> !cpu_word_valid);

endmodule

// File: tb/sim_cwf_line_fill.sv
`timescale 1ns/1ps
module sim_cwf_line_fill;
  localparam int LINE = 256, BUS = 32, AW = 32, BEATS = LINE / BUS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, mem_req_ready = 1'b0, mem_beat_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [BUS-1:0] mem_beat_data = '0;
  wire req_ready, busy, mem_req_valid, cpu_word_valid, line_done;
  wire [AW-1:0] mem_req_addr;
  wire [BUS-1:0] cpu_word_data;
  wire [LINE-1:0] line_data;

  cwf_line_fill #(.LINE_BITS(LINE), .BUS_BITS(BUS), .ADDR_BITS(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .busy(busy), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
    .mem_beat_valid(mem_beat_valid), .mem_beat_data(mem_beat_data),
    .cpu_word_valid(cpu_word_valid), .cpu_word_data(cpu_word_data),
    .line_done(line_done), .line_data(line_data));

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [LINE-1:0] act, input logic [LINE-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int ph = 0, m_crit = 0, m_got = 0;
  logic [BUS-1:0] m_words [BEATS];
  logic m_cpu_v = 0, m_done = 0;
  logic [BUS-1:0] m_cpu_d = '0;
  logic [AW-1:0] m_addr = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; m_cpu_v = 0; m_done = 0; m_cpu_d = '0; m_addr = '0;
      foreach (m_words[i]) m_words[i] = '0;
    end else begin
      m_cpu_v = 0; m_done = 0;
      if (ph == 0) begin
        if (req_valid) begin
          m_crit = (req_addr / (BUS / 8)) % BEATS;
          m_addr = req_addr - (req_addr % (BUS / 8));
          ph = 1;
        end
      end else if (ph == 1) begin
        if (mem_req_ready) begin ph = 2; m_got = 0; end
      end else if (mem_beat_valid) begin
        m_words[(m_crit + m_got) % BEATS] = mem_beat_data;
        if (m_got == 0) begin m_cpu_v = 1; m_cpu_d = mem_beat_data; end
        m_got++;
        if (m_got == BEATS) begin m_done = 1; ph = 0; end
      end
    end
  end

  function automatic logic [LINE-1:0] model_line();
    logic [LINE-1:0] v;
    for (int j = 0; j < BEATS; j++) v[j*BUS +: BUS] = m_words[j];
    return v;
  endfunction

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R1 req_ready", LINE'(req_ready), LINE'(ph == 0));
    chk("R1/R7 busy", LINE'(busy), LINE'(ph != 0));
    chk("R2 mem_req_valid", LINE'(mem_req_valid), LINE'(ph == 1));
    if (ph == 1) chk("R2 mem_req_addr", LINE'(mem_req_addr), LINE'(m_addr));
    chk("R5 cpu_word_valid", LINE'(cpu_word_valid), LINE'(m_cpu_v));
    if (m_cpu_v) chk("R5 cpu_word_data", LINE'(cpu_word_data), LINE'(m_cpu_d));
    chk("R6 line_done", LINE'(line_done), LINE'(m_done));
    chk("R3/R4/R8 line_data", line_data, model_line());
  end

  function automatic logic [BUS-1:0] mem_word(input logic [AW-1:0] base, input int idx);
    return base ^ (BUS'(idx) * 32'h01010101) ^ 32'hA5000000;
  endfunction

  task automatic fill(input logic [AW-1:0] a, input int rdy_dly, input int gap, input bit intrude);
    logic [AW-1:0] base;
    int crit, w;
    logic [LINE-1:0] img;
    base = a & ~AW'(LINE / 8 - 1);
    crit = (a >> 2) % BEATS;
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    w = 0;
    while (!mem_req_valid && w < 50) begin @(negedge clk); w++; end
    for (int d = 0; d < rdy_dly; d++) begin
      mem_beat_valid = 1; mem_beat_data = 32'hDEAD0000 + BUS'(d);  // R3: stray before handshake
      @(negedge clk);
    end
    mem_beat_valid = 0;
    mem_req_ready = 1;
    @(negedge clk);
    mem_req_ready = 0;
    for (int k = 0; k < BEATS; k++) begin
      for (int g = 0; g < gap; g++) begin
        req_valid = intrude; req_addr = 32'h0000_7F00;  // R7
        @(negedge clk);
      end
      req_valid = intrude; req_addr = 32'h0000_7F00;
      mem_beat_valid = 1; mem_beat_data = mem_word(base, (crit + k) % BEATS);
      @(negedge clk);
      mem_beat_valid = 0;
    end
    req_valid = 0;
    for (int j = 0; j < BEATS; j++) img[j*BUS +: BUS] = mem_word(base, j);
    chk("R6 done pulse after last beat", LINE'(line_done), LINE'(1));
    chk("R4 wrap-order line image", line_data, img);
    @(negedge clk);
    chk("R6 done single cycle", LINE'(line_done), LINE'(0));
    chk("R7 no request after intrusion", LINE'(mem_req_valid), LINE'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 line_data reset", line_data, '0);
    chk("R9 cpu_word_valid reset", LINE'(cpu_word_valid), '0);
    chk("R9 line_done reset", LINE'(line_done), '0);
    chk("R9 mem_req_valid reset", LINE'(mem_req_valid), '0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle ready", LINE'(req_ready), LINE'(1));
    fill(32'h0000_1000, 0, 0, 0);
    mem_beat_valid = 1; mem_beat_data = 32'hBAD0BAD0;  // R3: idle stray
    @(negedge clk);
    mem_beat_valid = 0;
    fill(32'h0000_201C, 3, 0, 1);
    fill(32'h0000_30E6, 1, 2, 0);
    fill(32'h0000_4008, 2, 1, 1);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule